// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of a memory operand in a segmented 32-bit machine. Each request gives a base register value, an index register value with a scale code, a displacement with a size code, a segment selector and the current privilege level. The block adds the enabled terms to form the effective offset. It then looks up the chosen segment's descriptor in a small local descriptor store and adds the segment base to form the linear address. It also reports whether the access runs past the segment limit and whether the privilege rules forbid it.

The datapath has two register stages and takes one request per cycle with no stalls. The first stage registers the offset and reads the descriptor synchronously, the way a block RAM reads. The second stage registers the linear address, the offset and both fault flags. A valid bit travels down the pipe with the data. A separate write port fills the descriptor store, one entry per cycle. Fetching descriptors from memory and page translation belong to other blocks.

Top module: `seg_agu`

## Requirements
- R1: The offset is (base if base_en) + (index × scale if index_en) + extended displacement, taken modulo 2^32. A disabled term contributes zero.
- R2: scale_code values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively.
- R3: disp_code 0 adds no displacement. disp_code 1 adds disp_val[7:0] sign-extended to 32 bits. disp_code 2 and 3 add all 32 bits of disp_val.
- R4: The selector is split as follows: bits [1:0] are the requested privilege level, bit 2 picks the table (0 = global, 1 = local), and bits [IDX_W+2:3] pick the entry. The linear address is the selected descriptor's base plus the offset, modulo 2^32.
- R5: A limit fault is raised when offset + size − 1 is greater than the descriptor limit. This sum is computed without wrap-around. acc_size 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes.
- R6: A privilege fault is raised when the larger of the selector's requested level and cur_pl is greater than the descriptor's privilege level.
- R7: A request accepted on a clock edge appears on the outputs two edges later with out_valid high. Requests may be issued back to back, one per cycle, and each result arrives in order.
- R8: Both fault flags are low whenever out_valid is low.
- R9: A descriptor write takes effect for requests issued in the following cycle or later. A request that reads the same entry in the same cycle as its write sees the entry's previous contents.
- R10: A selector with any entry-index bit set at or above bit IDX_W+3 points outside the store and raises a limit fault.
- R11: After reset, out_valid and both fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| base_en | input | 1 | Base term present |
| index_val | input | 32 | Index register value |
| index_en | input | 1 | Index term present |
| scale_code | input | 2 | Index scale code |
| disp_val | input | 32 | Displacement field |
| disp_code | input | 2 | Displacement size code |
| sel | input | SEL_W | Segment selector |
| cur_pl | input | 2 | Current privilege level |
| acc_size | input | 2 | Access size code |
| dsc_we | input | 1 | Descriptor write enable |
| dsc_waddr | input | IDX_W+1 | Descriptor entry written: {table bit, index} |
| dsc_wbase | input | 32 | Descriptor base written |
| dsc_wlimit | input | 32 | Descriptor limit written |
| dsc_wdpl | input | 2 | Descriptor privilege level written |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Effective offset |
| out_linear | output | 32 | Linear address |
| out_lim_fault | output | 1 | Limit violation |
| out_priv_fault | output | 1 | Privilege violation |

## Verification
Two functions can fall in the same cycle: a descriptor update, and a lookup of that same entry by a request. The bench provokes this by driving a write and a request aimed at the same entry in one cycle. It expects the result to carry the old base, limit and privilege level, and it expects the next request to the entry to see the new ones. The limit check and the privilege check can also both fire on a single result. One test is built so that both fire at once, and the two flags are judged separately.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam int ADDR_W = 32;
  localparam int PL_W   = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [PL_W-1:0]   dpl;
  } seg_desc_t;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B8   = 2'd1,
    DISP_W32  = 2'd2,
    DISP_W32B = 2'd3
  } disp_code_e;

  function automatic logic [ADDR_W-1:0] disp_extend(input logic [1:0] code,
                                                    input logic [ADDR_W-1:0] raw);
    logic [ADDR_W-1:0] r;
    case (disp_code_e'(code))
      DISP_NONE: r = '0;
      DISP_B8:   r = {{(ADDR_W-8){raw[7]}}, raw[7:0]};
      default:   r = raw;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    logic [2:0] r;
    case (code)
      2'd0:    r = 3'd1;
      2'd1:    r = 3'd2;
      default: r = 3'd4;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import seg_agu_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDX_W:0]  waddr,
  input  seg_desc_t       wdata,
  input  logic            re,
  input  logic [IDX_W:0]  raddr,
  output seg_desc_t       rdata
);
  localparam int DEPTH = 1 << (IDX_W + 1);

  seg_desc_t mem [DEPTH];

  // Read-first synchronous port pair, no reset: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_off_stage.sv
module seg_off_stage
  import seg_agu_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_en,
  input  logic [ADDR_W-1:0] index_val,
  input  logic              index_en,
  input  logic [1:0]        scale_code,
  input  logic [ADDR_W-1:0] disp_val,
  input  logic [1:0]        disp_code,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PL_W-1:0]   cur_pl,
  input  logic [1:0]        acc_size,
  output logic              s1_valid,
  output logic [ADDR_W-1:0] s1_off,
  output logic [PL_W-1:0]   s1_eff_pl,
  output logic [2:0]        s1_size,
  output logic              s1_oob
);
  localparam int HI_W = SEL_W - 3 - IDX_W;

  logic [ADDR_W-1:0] base_term, index_term, disp_term, off_c;
  logic [PL_W-1:0]   rpl, eff_pl;
  logic              oob_c;

  assign base_term  = base_en  ? base_val : '0;
  assign index_term = index_en ? (index_val << scale_code) : '0;
  assign disp_term  = disp_extend(disp_code, disp_val);
  assign off_c      = base_term + index_term + disp_term;

  assign rpl    = sel[PL_W-1:0];
  assign eff_pl = (rpl > cur_pl) ? rpl : cur_pl;

  generate
    if (HI_W > 0) begin : g_hi
      assign oob_c = |sel[SEL_W-1:IDX_W+3];
    end else begin : g_nohi
      assign oob_c = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      s1_off    <= off_c;
      s1_eff_pl <= eff_pl;
      s1_size   <= size_bytes(acc_size);
      s1_oob    <= oob_c;
    end
  end
endmodule

// File: rtl/seg_chk_stage.sv
module seg_chk_stage
  import seg_agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [ADDR_W-1:0] s1_off,
  input  logic [PL_W-1:0]   s1_eff_pl,
  input  logic [2:0]        s1_size,
  input  logic              s1_oob,
  input  seg_desc_t         desc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_offset,
  output logic [ADDR_W-1:0] out_linear,
  output logic              out_lim_fault,
  output logic              out_priv_fault
);
  logic [ADDR_W:0] last_byte;
  logic            lim_c, priv_c;

  // One bit wider than the address so a run past 2^32 counts as a fault.
  assign last_byte = {1'b0, s1_off} + {{(ADDR_W-2){1'b0}}, s1_size} - 1'b1;
  assign lim_c     = s1_oob || (last_byte > {1'b0, desc.limit});
  assign priv_c    = s1_eff_pl > desc.dpl;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_lim_fault  <= 1'b0;
      out_priv_fault <= 1'b0;
    end else begin
      out_valid      <= s1_valid;
      out_lim_fault  <= s1_valid && lim_c;
      out_priv_fault <= s1_valid && priv_c;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      out_offset <= s1_off;
      out_linear <= desc.base + s1_off;
    end
  end
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:0]       base_val,
  input  logic              base_en,
  input  logic [31:0]       index_val,
  input  logic              index_en,
  input  logic [1:0]        scale_code,
  input  logic [31:0]       disp_val,
  input  logic [1:0]        disp_code,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        cur_pl,
  input  logic [1:0]        acc_size,
  input  logic              dsc_we,
  input  logic [IDX_W:0]    dsc_waddr,
  input  logic [31:0]       dsc_wbase,
  input  logic [31:0]       dsc_wlimit,
  input  logic [1:0]        dsc_wdpl,
  output logic              out_valid,
  output logic [31:0]       out_offset,
  output logic [31:0]       out_linear,
  output logic              out_lim_fault,
  output logic              out_priv_fault
);
  logic              s1_valid, s1_oob;
  logic [ADDR_W-1:0] s1_off;
  logic [PL_W-1:0]   s1_eff_pl;
  logic [2:0]        s1_size;
  seg_desc_t         wdesc, rdesc;
  logic [IDX_W:0]    raddr;

  assign wdesc = '{base: dsc_wbase, limit: dsc_wlimit, dpl: dsc_wdpl};
  assign raddr = {sel[2], sel[IDX_W+2:3]};

  seg_desc_file #(.IDX_W(IDX_W)) desc_i (
    .clk(clk), .we(dsc_we), .waddr(dsc_waddr), .wdata(wdesc),
    .re(req_valid), .raddr(raddr), .rdata(rdesc)
  );

  seg_off_stage #(.IDX_W(IDX_W), .SEL_W(SEL_W)) off_i (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .base_val(base_val), .base_en(base_en),
    .index_val(index_val), .index_en(index_en), .scale_code(scale_code),
    .disp_val(disp_val), .disp_code(disp_code),
    .sel(sel), .cur_pl(cur_pl), .acc_size(acc_size),
    .s1_valid(s1_valid), .s1_off(s1_off), .s1_eff_pl(s1_eff_pl),
    .s1_size(s1_size), .s1_oob(s1_oob)
  );

  seg_chk_stage chk_st_i (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_off(s1_off), .s1_eff_pl(s1_eff_pl),
    .s1_size(s1_size), .s1_oob(s1_oob), .desc(rdesc),
    .out_valid(out_valid), .out_offset(out_offset), .out_linear(out_linear),
    .out_lim_fault(out_lim_fault), .out_priv_fault(out_priv_fault)
  );
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [31:0]      base_val,
  input logic             base_en,
  input logic [31:0]      index_val,
  input logic             index_en,
  input logic [1:0]       scale_code,
  input logic [31:0]      disp_val,
  input logic [1:0]       disp_code,
  input logic [SEL_W-1:0] sel,
  input logic [1:0]       cur_pl,
  input logic             out_valid,
  input logic [31:0]      out_offset,
  input logic             out_lim_fault,
  input logic             out_priv_fault
);
  logic [1:0]  age;
  logic [31:0] exp_off;
  logic [31:0] disp_x;
  logic        pl_zero;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  always_comb begin
    if (disp_code == 2'd0)      disp_x = 32'd0;
    else if (disp_code == 2'd1) disp_x = 32'(signed'(disp_val[7:0]));
    else                        disp_x = disp_val;
    exp_off = (base_en ? base_val : 32'd0)
            + (index_en ? index_val * (32'd1 << scale_code) : 32'd0)
            + disp_x;
  end

  assign pl_zero = (sel[1:0] == 2'd0) && (cur_pl == 2'd0);

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(req_valid, 2))); // R7

  AST_OFFSET_SUM: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid) |-> (out_offset == $past(exp_off, 2))); // R1

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_lim_fault && !out_priv_fault)); // R8

  AST_TOP_PL_NO_PRIV: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid && $past(pl_zero, 2)) |-> !out_priv_fault); // R6
endmodule

bind seg_agu seg_agu_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .base_val(base_val), .base_en(base_en),
  .index_val(index_val), .index_en(index_en), .scale_code(scale_code),
  .disp_val(disp_val), .disp_code(disp_code),
  .sel(sel), .cur_pl(cur_pl),
  .out_valid(out_valid), .out_offset(out_offset),
  .out_lim_fault(out_lim_fault), .out_priv_fault(out_priv_fault)
);

// File: tb/seg_agu_tb_top.sv
module seg_agu_tb_top;
  localparam int IDX_W = 3;
  localparam int SEL_W = 16;
  localparam int NENT  = 1 << (IDX_W + 1);

  logic clk = 1'b0;
  logic rst;
  logic req_valid, base_en, index_en, dsc_we;
  logic [31:0] base_val, index_val, disp_val, dsc_wbase, dsc_wlimit;
  logic [1:0]  scale_code, disp_code, cur_pl, acc_size, dsc_wdpl;
  logic [SEL_W-1:0] sel;
  logic [IDX_W:0]   dsc_waddr;
  logic        out_valid, out_lim_fault, out_priv_fault;
  logic [31:0] out_offset, out_linear;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_base  [NENT];
  logic [31:0] m_limit [NENT];
  logic [1:0]  m_dpl   [NENT];

  always #4 clk = ~clk;

  seg_agu #(.IDX_W(IDX_W), .SEL_W(SEL_W)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_off(input logic [31:0] b, input logic be,
      input logic [31:0] x, input logic xe, input logic [1:0] sc,
      input logic [31:0] d, input logic [1:0] dc);
    logic [31:0] dd;
    if (dc == 2'd0) dd = 0;
    else if (dc == 2'd1) dd = {{24{d[7]}}, d[7:0]};
    else dd = d;
    return (be ? b : 32'd0) + (xe ? x * (32'd1 << sc) : 32'd0) + dd;
  endfunction

  task automatic wr_desc(input int e, input logic [31:0] b, input logic [31:0] l, input logic [1:0] p);
    @(negedge clk);
    dsc_we = 1; dsc_waddr = e[IDX_W:0]; dsc_wbase = b; dsc_wlimit = l; dsc_wdpl = p;
    m_base[e] = b; m_limit[e] = l; m_dpl[e] = p;
    @(negedge clk);
    dsc_we = 0;
  endtask

  task automatic drive(input logic [31:0] b, input logic be, input logic [31:0] x,
      input logic xe, input logic [1:0] sc, input logic [31:0] d, input logic [1:0] dc,
      input logic [SEL_W-1:0] s, input logic [1:0] cp, input logic [1:0] sz);
    req_valid = 1; base_val = b; base_en = be; index_val = x; index_en = xe;
    scale_code = sc; disp_val = d; disp_code = dc; sel = s; cur_pl = cp; acc_size = sz;
  endtask

  // Full check of one result against the bench model, using the given descriptor values.
  task automatic expect_res(input string tag, input logic [31:0] off, input logic [31:0] db,
      input logic [31:0] dl, input logic [1:0] dp, input logic [SEL_W-1:0] s,
      input logic [1:0] cp, input logic [1:0] sz);
    logic [32:0] last;
    logic [1:0]  epl;
    logic        lf, pf;
    last = {1'b0, off} + ((sz == 0) ? 33'd1 : (sz == 1) ? 33'd2 : 33'd4) - 33'd1;
    lf = (last > {1'b0, dl}) || (|s[SEL_W-1:IDX_W+3]);
    epl = (s[1:0] > cp) ? s[1:0] : cp;
    pf = epl > dp;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " offset"}, out_offset, off);
    chk({tag, " linear"}, out_linear, db + off);
    chk({tag, " limfault"}, {31'd0, out_lim_fault}, {31'd0, lf});
    chk({tag, " privfault"}, {31'd0, out_priv_fault}, {31'd0, pf});
  endtask

  task automatic one_req(input string tag, input logic [31:0] b, input logic be,
      input logic [31:0] x, input logic xe, input logic [1:0] sc, input logic [31:0] d,
      input logic [1:0] dc, input logic [SEL_W-1:0] s, input logic [1:0] cp, input logic [1:0] sz);
    int e;
    logic [31:0] off;
    e = {s[2], s[IDX_W+2:3]};
    off = m_off(b, be, x, xe, sc, d, dc);
    @(negedge clk);
    drive(b, be, x, xe, sc, d, dc, s, cp, sz);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    expect_res(tag, off, m_base[e], m_limit[e], m_dpl[e], s, cp, sz);
  endtask

  function automatic logic [SEL_W-1:0] mk_sel(input int idx, input logic ti, input logic [1:0] rpl);
    return {idx[SEL_W-4:0], ti, rpl};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R11 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11 flags after reset", {30'd0, out_lim_fault, out_priv_fault}, 32'd0);
  endtask

  task automatic t_offsets();
    one_req("R1 base only", 32'h0000_1000, 1, 32'hDEAD, 0, 0, 32'h0, 0, mk_sel(1,0,0), 0, 0);
    one_req("R1 index only", 32'h5555, 0, 32'h20, 1, 0, 32'h0, 0, mk_sel(1,0,0), 0, 0);
    for (int s = 0; s < 4; s++)
      one_req("R2 scale", 32'h100, 1, 32'h10, 1, s[1:0], 32'h0, 0, mk_sel(1,0,0), 0, 0);
    one_req("R3 disp8 negative", 32'h200, 1, 0, 0, 0, 32'hFFFF_FF80, 1, mk_sel(1,0,0), 0, 0);
    one_req("R3 disp8 positive", 32'h200, 1, 0, 0, 0, 32'hAAAA_AA7F, 1, mk_sel(1,0,0), 0, 0);
    one_req("R3 disp32", 32'h200, 1, 0, 0, 0, 32'h0012_3456, 2, mk_sel(1,0,0), 0, 0);
    one_req("R3 disp none", 32'h200, 1, 0, 0, 0, 32'h0012_3456, 0, mk_sel(1,0,0), 0, 0);
    one_req("R1 wrap", 32'hFFFF_FFF0, 1, 32'h8, 1, 2'd2, 32'h4, 3, mk_sel(1,0,0), 0, 0);
  endtask

  task automatic t_tables();
    one_req("R4 global entry", 32'h40, 1, 0, 0, 0, 0, 0, mk_sel(3,0,0), 0, 0);
    one_req("R4 local entry", 32'h40, 1, 0, 0, 0, 0, 0, mk_sel(3,1,0), 0, 0);
  endtask

  task automatic t_limits();
    // Entry 2 global: limit 0xFF
    one_req("R5 last byte at limit", 32'hFE, 1, 0, 0, 0, 0, 0, mk_sel(2,0,0), 0, 2'd1);
    one_req("R5 dword over limit", 32'hFE, 1, 0, 0, 0, 0, 0, mk_sel(2,0,0), 0, 2'd2);
    one_req("R5 byte over limit", 32'h100, 1, 0, 0, 0, 0, 0, mk_sel(2,0,0), 0, 2'd0);
    // Entry 4 global: full-range limit, access crossing 2^32
    one_req("R5 no wrap", 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0, mk_sel(4,0,0), 0, 2'd1);
    one_req("R10 index out of table", 32'h10, 1, 0, 0, 0, 0, 0, mk_sel(9,0,0), 0, 0);
  endtask

  task automatic t_priv();
    // Entry 5 global: dpl 2
    one_req("R6 rpl above dpl", 32'h10, 1, 0, 0, 0, 0, 0, mk_sel(5,0,3), 0, 0);
    one_req("R6 cpl above dpl", 32'h10, 1, 0, 0, 0, 0, 0, mk_sel(5,0,0), 3, 0);
    one_req("R6 equal levels", 32'h10, 1, 0, 0, 0, 0, 0, mk_sel(5,0,2), 1, 0);
    // Both faults in one result
    one_req("R5 R6 both faults", 32'h1000, 1, 0, 0, 0, 0, 0, mk_sel(5,0,3), 3, 2'd2);
  endtask

  task automatic t_collide();
    logic [31:0] ob, ol;
    logic [1:0]  op;
    ob = m_base[6]; ol = m_limit[6]; op = m_dpl[6];
    @(negedge clk);
    drive(32'h80, 1, 0, 0, 0, 0, 0, mk_sel(6,0,3), 0, 0);
    dsc_we = 1; dsc_waddr = 4'd6; dsc_wbase = 32'h7700_0000; dsc_wlimit = 32'h10; dsc_wdpl = 2'd0;
    @(negedge clk);
    req_valid = 0; dsc_we = 0;
    m_base[6] = 32'h7700_0000; m_limit[6] = 32'h10; m_dpl[6] = 2'd0;
    @(negedge clk);
    expect_res("R9 same-cycle old entry", 32'h80, ob, ol, op, mk_sel(6,0,3), 0, 0);
    one_req("R9 next request new entry", 32'h80, 1, 0, 0, 0, 0, 0, mk_sel(6,0,3), 0, 0);
  endtask

  task automatic t_stream();
    logic [31:0] offs [4];
    for (int k = 0; k < 4; k++) offs[k] = 32'h300 + k * 32'h11;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2)
        expect_res("R7 back to back", offs[k-2], m_base[7], m_limit[7], m_dpl[7],
                   mk_sel(7,0,0), 0, 0);
      if (k < 4) drive(offs[k], 1, 0, 0, 0, 0, 0, mk_sel(7,0,0), 0, 0);
      else req_valid = 0;
    end
    @(negedge clk);
    chk("R7 R8 idle after stream", {29'd0, out_valid, out_lim_fault, out_priv_fault}, 32'd0);
  endtask

  initial begin
    rst = 1; req_valid = 0; dsc_we = 0; dsc_waddr = 0; dsc_wbase = 0; dsc_wlimit = 0; dsc_wdpl = 0;
    base_val = 0; base_en = 0; index_val = 0; index_en = 0; scale_code = 0;
    disp_val = 0; disp_code = 0; sel = 0; cur_pl = 0; acc_size = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    for (int e = 0; e < NENT; e++)
      wr_desc(e, 32'h0010_0000 * (e + 1), 32'h000F_FFFF, 2'd3);
    wr_desc(2, 32'h0002_0000, 32'h0000_00FF, 2'd3);
    wr_desc(4, 32'h0000_0000, 32'hFFFF_FFFF, 2'd3);
    wr_desc(5, 32'h0005_0000, 32'h0000_0FFF, 2'd2);
    wr_desc(11, 32'hB000_0000, 32'h000F_FFFF, 2'd3);
    t_offsets();
    t_tables();
    t_limits();
    t_priv();
    t_collide();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired R7 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule